// File: doc/BRIEF.md
# Codec Register Command Port

This block lets a host processor read and write the control registers of an external audio codec that sits on a frame-based serial link. The host programs three local registers: a command address, a command data word, and a control word. The control word carries a link-sync enable, a frame-valid enable, a read/write select and a command-valid bit. The engine hands the command to the link in the next frame slot that the link offers. Once the command has left, it drops command-valid by itself. Software polls that bit to learn that the command was sent.

For a read, the engine then waits for the codec's reply. It stores the returned word and raises a status-valid flag that software polls. Reading the stored word clears the flag, so data left over from an earlier read is never taken for a fresh answer. Software reads the stored word once before it issues each read. The engine does not shift bits onto the link itself. A slot offer from the link and a same-cycle acceptance pulse from the engine take the place of the serialiser. A codec-ready input is shown to software as a read-only status bit.

Top module: `codec_cmd_port`

## Requirements
- R1: After reset, the address, data, control, status and stored-data registers all read 0, apart from the codec-ready mirror, and `tx_fire` is 0.
- R2: Bits [7:0] of the address register are driven on `tx_index` and bits [9:8] on `tx_codec`. The register reads back as written.
- R3: Writing the control register (select 2) with bit 0 set makes command-valid 1. The control register reads back as {sync bit 3, frame bit 2, read bit 1, command-valid bit 0}. Command-valid reads 0 from the cycle after `tx_fire`, and each command fires exactly once.
- R4: `tx_fire` is 1 only in a cycle where `link_slot` is 1, command-valid is 1, and both control bit 2 (frame valid) and bit 3 (sync enable) are set. Otherwise the command stays pending.
- R5: After a read command has fired, a cycle with `link_rsp_valid` high stores `link_rsp_data` in the stored-data register (select 4) and sets status bit 0 (status valid).
- R6: A host read of the stored-data register clears status bit 0 on the following clock edge.
- R7: Accepting a new command clears status bit 0, even if the stored data was never read.
- R8: Host writes to the address, data or control register are ignored while command-valid is 1.
- R9: A response that arrives while no read is outstanding changes neither status bit 0 nor the stored data.
- R10: Status bit 1 mirrors the `codec_ready` input.
- R11: For a fired command, `tx_is_read` equals control bit 1 and `tx_wdata` equals the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_sel | input | 3 | Register select: 0 address, 1 data, 2 control, 3 status, 4 stored data |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data (combinational) |
| link_slot | input | 1 | Link offers a command slot this cycle |
| tx_fire | output | 1 | Command accepted into the offered slot |
| tx_codec | output | 2 | Codec number of the command |
| tx_index | output | 8 | Codec register index |
| tx_wdata | output | 16 | Write data for the command |
| tx_is_read | output | 1 | Command is a read |
| link_rsp_valid | input | 1 | Codec reply present |
| link_rsp_data | input | 16 | Codec reply data |
| codec_ready | input | 1 | Codec ready indication |

## Verification
The bench sets only one of the two link-enable bits and offers slots. It checks that nothing fires, which catches an engine that tests only one of the enables. It keeps a slot offered for one more cycle after a command fires. An engine that failed to clear command-valid would send the command twice. It tries to rewrite the address, data and control registers while a command waits for a slot. A design without the busy lock would change the command before it is sent. The bench also sends a reply with no read outstanding, issues a new command over an unread status, and reads the stored data. These show whether stale replies are held or the status flag is left set.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam logic [2:0] SEL_ADDR  = 3'd0;
  localparam logic [2:0] SEL_WDATA = 3'd1;
  localparam logic [2:0] SEL_CTRL  = 3'd2;
  localparam logic [2:0] SEL_STAT  = 3'd3;
  localparam logic [2:0] SEL_SDATA = 3'd4;

  localparam int CTL_GO  = 0;
  localparam int CTL_RD  = 1;
  localparam int CTL_FRM = 2;
  localparam int CTL_SYN = 3;

  localparam int ST_VALID = 0;
  localparam int ST_READY = 1;
endpackage

// File: rtl/ccp_host_regs.sv
module ccp_host_regs
  import ccp_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int CODEC_W = 2,
  parameter int DATA_W  = 16,
  localparam int AW     = IDX_W + CODEC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_addr,
  input  logic              wr_data,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  output logic [AW-1:0]     addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic              ctl_rd_q,
  output logic              ctl_frm_q,
  output logic              ctl_syn_q,
  output logic              go
);
  logic [AW-1:0]     addr_d;
  logic [DATA_W-1:0] data_d;
  logic              rd_d, frm_d, syn_d;
  logic              addr_en, data_en, ctrl_en;

  // Writes land only while no command is pending.
  assign addr_en = wr_addr & ~busy;
  assign data_en = wr_data & ~busy;
  assign ctrl_en = wr_ctrl & ~busy;
  assign go      = ctrl_en & wdata[CTL_GO];

  always_comb begin
    addr_d = addr_q;
    data_d = data_q;
    rd_d   = ctl_rd_q;
    frm_d  = ctl_frm_q;
    syn_d  = ctl_syn_q;
    if (addr_en) addr_d = wdata[AW-1:0];
    if (data_en) data_d = wdata;
    if (ctrl_en) begin
      rd_d  = wdata[CTL_RD];
      frm_d = wdata[CTL_FRM];
      syn_d = wdata[CTL_SYN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      data_q    <= '0;
      ctl_rd_q  <= 1'b0;
      ctl_frm_q <= 1'b0;
      ctl_syn_q <= 1'b0;
    end else begin
      addr_q    <= addr_d;
      data_q    <= data_d;
      ctl_rd_q  <= rd_d;
      ctl_frm_q <= frm_d;
      ctl_syn_q <= syn_d;
    end
  end

  // R8: a pending command shields its operands
  assert_hold_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (wr_addr || wr_data || wr_ctrl)) |=>
      ($stable(addr_q) && $stable(data_q) && $stable({ctl_syn_q, ctl_frm_q, ctl_rd_q})));
endmodule

// File: rtl/ccp_cmd_engine.sv
module ccp_cmd_engine #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              ctl_rd,
  input  logic              ctl_frm,
  input  logic              ctl_syn,
  input  logic              link_slot,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              sdata_rd,
  output logic              fire,
  output logic              cmd_valid_q,
  output logic              stat_valid_q,
  output logic [DATA_W-1:0] sdata_q
);
  logic              cv_d, wait_q, wait_d, sv_d;
  logic [DATA_W-1:0] sd_d;
  logic              take_rsp;

  assign fire     = cmd_valid_q & link_slot & ctl_frm & ctl_syn;
  assign take_rsp = rsp_valid & wait_q & ~go;

  always_comb begin
    cv_d   = cmd_valid_q;
    wait_d = wait_q;
    sv_d   = stat_valid_q;
    sd_d   = sdata_q;
    if (go)        cv_d = 1'b1;
    else if (fire) cv_d = 1'b0;

    if (go)            wait_d = 1'b0;
    else if (fire)     wait_d = ctl_rd;
    else if (take_rsp) wait_d = 1'b0;

    if (go)            sv_d = 1'b0;
    else if (take_rsp) sv_d = 1'b1;
    else if (sdata_rd) sv_d = 1'b0;

    if (take_rsp) sd_d = rsp_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid_q  <= 1'b0;
      wait_q       <= 1'b0;
      stat_valid_q <= 1'b0;
      sdata_q      <= '0;
    end else begin
      cmd_valid_q  <= cv_d;
      wait_q       <= wait_d;
      stat_valid_q <= sv_d;
      sdata_q      <= sd_d;
    end
  end

  // R3: command-valid drops once sent, and a command goes out only once
  assert_fire_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !cmd_valid_q);
  assert_single_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
  // R5: status-valid comes only from a reply
  assert_sv_from_reply_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_valid_q) |-> $past(rsp_valid));
  // R6: reading stored data retires the status
  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata_rd && !rsp_valid) |=> !stat_valid_q);
  // R7: a new command starts with a clean status
  assert_go_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (!stat_valid_q && cmd_valid_q));
endmodule

// File: rtl/codec_cmd_port.sv
module codec_cmd_port
  import ccp_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int CODEC_W = 2,
  parameter int DATA_W  = 16,
  localparam int AW     = IDX_W + CODEC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [2:0]         host_sel,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  input  logic               link_slot,
  output logic               tx_fire,
  output logic [CODEC_W-1:0] tx_codec,
  output logic [IDX_W-1:0]   tx_index,
  output logic [DATA_W-1:0]  tx_wdata,
  output logic               tx_is_read,
  input  logic               link_rsp_valid,
  input  logic [DATA_W-1:0]  link_rsp_data,
  input  logic               codec_ready
);
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] data_q, sdata_q;
  logic              rd_q, frm_q, syn_q, go, cv_q, sv_q, sdata_rd;

  assign sdata_rd = host_rd & (host_sel == SEL_SDATA);

  ccp_host_regs #(.IDX_W(IDX_W), .CODEC_W(CODEC_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_addr(host_wr & (host_sel == SEL_ADDR)),
    .wr_data(host_wr & (host_sel == SEL_WDATA)),
    .wr_ctrl(host_wr & (host_sel == SEL_CTRL)),
    .wdata(host_wdata), .busy(cv_q),
    .addr_q(addr_q), .data_q(data_q),
    .ctl_rd_q(rd_q), .ctl_frm_q(frm_q), .ctl_syn_q(syn_q), .go(go)
  );

  ccp_cmd_engine #(.DATA_W(DATA_W)) eng_i (
    .clk(clk), .rst_n(rst_n), .go(go),
    .ctl_rd(rd_q), .ctl_frm(frm_q), .ctl_syn(syn_q),
    .link_slot(link_slot), .rsp_valid(link_rsp_valid), .rsp_data(link_rsp_data),
    .sdata_rd(sdata_rd), .fire(tx_fire),
    .cmd_valid_q(cv_q), .stat_valid_q(sv_q), .sdata_q(sdata_q)
  );

  assign tx_index   = addr_q[IDX_W-1:0];
  assign tx_codec   = addr_q[AW-1:IDX_W];
  assign tx_wdata   = data_q;
  assign tx_is_read = rd_q;

  always_comb begin
    host_rdata = '0;
    case (host_sel)
      SEL_ADDR:  host_rdata[AW-1:0] = addr_q;
      SEL_WDATA: host_rdata = data_q;
      SEL_CTRL: begin
        host_rdata[CTL_GO]  = cv_q;
        host_rdata[CTL_RD]  = rd_q;
        host_rdata[CTL_FRM] = frm_q;
        host_rdata[CTL_SYN] = syn_q;
      end
      SEL_STAT: begin
        host_rdata[ST_VALID] = sv_q;
        host_rdata[ST_READY] = codec_ready;
      end
      SEL_SDATA: host_rdata = sdata_q;
      default:   host_rdata = '0;
    endcase
  end

  // R4: nothing leaves without an offered slot
  assert_fire_needs_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fire |-> (link_slot && cv_q));
endmodule

// File: tb/codec_cmd_port_tb.sv
module codec_cmd_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr, host_rd, link_slot, link_rsp_valid, codec_ready;
  logic [2:0]  host_sel;
  logic [15:0] host_wdata, host_rdata, link_rsp_data, tx_wdata;
  logic        tx_fire, tx_is_read;
  logic [1:0]  tx_codec;
  logic [7:0]  tx_index;
  int          n_chk = 0;
  int          n_bad = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  codec_cmd_port dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .link_slot(link_slot), .tx_fire(tx_fire), .tx_codec(tx_codec),
    .tx_index(tx_index), .tx_wdata(tx_wdata), .tx_is_read(tx_is_read),
    .link_rsp_valid(link_rsp_valid), .link_rsp_data(link_rsp_data),
    .codec_ready(codec_ready)
  );

  task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; host_wr = 0; host_rd = 0; host_sel = 0; host_wdata = 0;
    link_slot = 0; link_rsp_valid = 0; link_rsp_data = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic hwrite(input logic [2:0] s, input logic [15:0] v);
    @(negedge clk);
    host_sel = s; host_wdata = v; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [2:0] s, output logic [15:0] v);
    @(negedge clk);
    host_sel = s; host_rd = 1'b1;
    #1 v = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic reply(input logic [15:0] d);
    @(negedge clk);
    link_rsp_valid = 1'b1; link_rsp_data = d;
    @(negedge clk);
    link_rsp_valid = 1'b0;
  endtask

  // offers one slot, returns fire and read flag seen in that cycle
  task automatic slot_once(output logic f, output logic r, output logic [15:0] wd);
    @(negedge clk);
    link_slot = 1'b1;
    #1 f = tx_fire; r = tx_is_read; wd = tx_wdata;
    @(negedge clk);
    link_slot = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    do_reset();
    for (int s = 0; s < 5; s++) begin
      hread(3'(s), v);
      check($sformatf("R1 reset value sel %0d", s), v, 16'h0);
    end
    check("R1 no fire after reset", {15'h0, tx_fire}, 16'h0);
  endtask

  task automatic t_addr();
    logic [15:0] v;
    hwrite(3'd0, 16'h02A5);
    hread(3'd0, v);
    check("R2 address readback", v, 16'h02A5);
    check("R2 index field", {8'h0, tx_index}, 16'h00A5);
    check("R2 codec field", {14'h0, tx_codec}, 16'h0002);
  endtask

  task automatic t_write_cmd();
    logic [15:0] v, wd;
    logic f, r;
    hwrite(3'd1, 16'h1234);
    hwrite(3'd2, 16'h000D);
    hread(3'd2, v);
    check("R3 command-valid set", v, 16'h000D);
    check("R4 no fire without slot", {15'h0, tx_fire}, 16'h0);
    @(negedge clk);
    link_slot = 1'b1;
    #1 f = tx_fire; r = tx_is_read; wd = tx_wdata;
    check("R4 fire in open slot", {15'h0, f}, 16'h1);
    check("R11 write command not read", {15'h0, r}, 16'h0);
    check("R11 write data on link", wd, 16'h1234);
    @(negedge clk);
    #1 check("R3 single fire with slot held", {15'h0, tx_fire}, 16'h0);
    link_slot = 1'b0;
    hread(3'd2, v);
    check("R3 command-valid self clears", v, 16'h000C);
    reply(16'hBEEF);
    hread(3'd3, v);
    check("R9 stray reply no status", v, 16'h0);
    hread(3'd4, v);
    check("R9 stray reply no data", v, 16'h0);
  endtask

  task automatic t_gate();
    logic [15:0] v, wd;
    logic f, r;
    do_reset();
    hwrite(3'd2, 16'h0005);
    for (int i = 0; i < 3; i++) begin
      slot_once(f, r, wd);
      check("R4 no fire without sync enable", {15'h0, f}, 16'h0);
    end
    hread(3'd2, v);
    check("R4 command still pending", v, 16'h0005);
    do_reset();
    hwrite(3'd2, 16'h0009);
    slot_once(f, r, wd);
    check("R4 no fire without frame valid", {15'h0, f}, 16'h0);
    do_reset();
  endtask

  task automatic t_lock();
    logic [15:0] v, wd;
    logic f, r;
    hwrite(3'd0, 16'h0033);
    hwrite(3'd1, 16'h00AA);
    hwrite(3'd2, 16'h000D);
    hwrite(3'd0, 16'h0111);
    hwrite(3'd1, 16'h5555);
    hwrite(3'd2, 16'h000F);
    hread(3'd0, v);
    check("R8 address locked", v, 16'h0033);
    hread(3'd1, v);
    check("R8 data locked", v, 16'h00AA);
    hread(3'd2, v);
    check("R8 control locked", v, 16'h000D);
    slot_once(f, r, wd);
    check("R8 original command fires", {15'h0, f}, 16'h1);
  endtask

  task automatic t_read();
    logic [15:0] v, wd;
    logic f, r;
    hread(3'd4, v);
    hwrite(3'd0, 16'h0026);
    hwrite(3'd1, 16'h0000);
    hwrite(3'd2, 16'h000F);
    slot_once(f, r, wd);
    check("R11 read command fires", {14'h0, f, r}, 16'h0003);
    hread(3'd3, v);
    check("R5 no status before reply", v, 16'h0);
    reply(16'hCAFE);
    hread(3'd3, v);
    check("R5 status valid after reply", v, 16'h0001);
    hread(3'd4, v);
    check("R5 stored reply", v, 16'hCAFE);
    hread(3'd3, v);
    check("R6 read clears status", v, 16'h0);
    reply(16'h1111);
    hread(3'd3, v);
    check("R9 late reply no status", v, 16'h0);
    hread(3'd4, v);
    check("R9 late reply keeps data", v, 16'hCAFE);
  endtask

  task automatic t_new_cmd();
    logic [15:0] v, wd;
    logic f, r;
    hwrite(3'd2, 16'h000F);
    slot_once(f, r, wd);
    reply(16'h7777);
    hread(3'd3, v);
    check("R5 second reply sets status", v, 16'h0001);
    hwrite(3'd2, 16'h000D);
    hread(3'd3, v);
    check("R7 new command clears status", v, 16'h0);
    slot_once(f, r, wd);
    check("R7 new command fires", {15'h0, f}, 16'h1);
  endtask

  task automatic t_ready();
    logic [15:0] v;
    codec_ready = 1'b1;
    hread(3'd3, v);
    check("R10 ready mirrored high", v, 16'h0002);
    codec_ready = 1'b0;
    hread(3'd3, v);
    check("R10 ready mirrored low", v, 16'h0);
  endtask

  initial begin
    codec_ready = 1'b0;
    rst_n = 1'b0;
    t_reset();
    t_addr();
    t_write_cmd();
    t_gate();
    t_lock();
    t_read();
    t_new_cmd();
    t_ready();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule